// File: doc/BRIEF.md
# Prioritized Supply Selection Controller

This block is the digital core that chooses which of three supply rails feeds a shared load. Each rail comes with two comparator flags that report an over-limit and an under-limit reading, plus a reverse-voltage flag. The reverse-voltage flag is high when the load voltage sits far enough below that rail's input for a safe connection. A rail counts as validated only after it has stayed inside its window for a set number of slow timebase strobes. Each rail reports its state on an active-low valid flag. The block drives one gate-enable per rail for the external back-to-back switch pair.

The lowest-numbered validated rail always wins. When the choice changes, the connected switch opens first. All gates then stay off for a fixed dead time. The new switch closes only once its reverse flag allows it. Dropping the enable input opens every switch but leaves the validation timers running. Asserting shutdown opens every switch and also clears all validation progress.

Top module: `psel_ctrl`

## Requirements
- R1: A rail's `valid_n` bit goes low only after `VAL_TICKS` strobes of `tick` have been seen while that rail had neither `ov` nor `uv` set, with no interruption. Otherwise the bit is high. A rail can only become validated on a cycle that had `tick` high.
- R2: If `ov` or `uv` of a rail is high at a clock edge, that rail's `valid_n` is high after that edge. Its count restarts from zero, so a full `VAL_TICKS` strobes are needed again. Strobes seen while the rail is out of window are ignored.
- R3: The connected rail is the validated rail with the lowest index (bit 0 = highest priority). A higher-priority rail that validates takes over from a lower one that is connected.
- R4: With `en` low at a clock edge, all `gate_on` bits are low after that edge, and validation progress is kept. When `en` returns high, the highest-priority validated rail is connected again.
- R5: With `shdn` high at a clock edge, all `gate_on` bits are low and all `valid_n` bits are high after that edge. After release, every rail needs a full `VAL_TICKS` strobes before it validates.
- R6: At most one `gate_on` bit is high in any cycle. The gate output never moves directly from one rail to another without an all-off interval.
- R7: Once a gate falls, all gates stay off for at least `DEAD_CYC` cycles before any gate rises. If the reverse flag of the new rail is already high, exactly `DEAD_CYC`+1 cycles are all-off.
- R8: A gate rises only if that rail's `rev_ok` was high in the previous cycle. While it is low, the selected rail waits with all gates off, and it connects one cycle after `rev_ok` goes high.
- R9: A `gate_on` bit is high only if, in the previous cycle, that rail was validated, `en` was high and `shdn` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe of the slow validation timebase |
| ov | input | N_RAILS | Per-rail over-limit comparator flag, high = above window |
| uv | input | N_RAILS | Per-rail under-limit comparator flag, high = below window |
| rev_ok | input | N_RAILS | Per-rail reverse flag, high = output far enough below the rail input to connect |
| en | input | 1 | Enable, low opens all switches without clearing validation |
| shdn | input | 1 | Shutdown, high opens all switches and clears validation |
| valid_n | output | N_RAILS | Per-rail validated flag, active low |
| gate_on | output | N_RAILS | Per-rail switch-pair enable, high = closed |

## Verification
The bench counts tick strobes up to one short of the validation length and then to exactly that length. A design off by one would validate too early or too late. It measures the all-off gap during a switchover cycle by cycle, so a missing or short dead time shows up as a gap that is too small. A direct rail-to-rail move shows up as no gap at all. It holds a newly selected rail's reverse flag low and expects every gate to stay off. It drops a connected rail and brings it back to confirm that a fresh, full revalidation is needed. It then toggles enable and shutdown to show that only shutdown discards validation progress. A design that mixed the two up would either reconnect at once after shutdown or stay dark after re-enable.

// File: rtl/psel_pkg.sv
// Package: shared types for the prioritized supply selection controller.
// Assumes: nothing beyond standard SystemVerilog.
package psel_pkg;

    // Gate sequencer states.
    typedef enum logic [1:0] {
        SQ_OFF  = 2'd0,   // no rail selected, all gates off
        SQ_DEAD = 2'd1,   // dead time after a gate opened
        SQ_WAIT = 2'd2,   // rail selected, waiting for its reverse flag
        SQ_ON   = 2'd3    // selected rail connected
    } seq_state_e;

endpackage

// File: rtl/psel_rail_timer.sv
// Module: psel_rail_timer
// Counts timebase strobes while one rail sits inside its window. It flags
// the rail validated once the count reaches VAL_TICKS.
// Assumes: tick is a one-cycle strobe; shdn and out-of-window clear the count.
module psel_rail_timer #(
    parameter int VAL_TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ov,
    input  logic uv,
    input  logic shdn,
    output logic valid
);

    localparam int CW = $clog2(VAL_TICKS + 1);
    localparam logic [CW-1:0] CMAX = CW'(VAL_TICKS);

    logic [CW-1:0] count_q;
    logic          in_window;

    // Window test: neither limit comparator tripped.
    assign in_window = !ov && !uv;

    // Strobe counter: restart on reset, shutdown or window exit, else saturate at CMAX.
    always_ff @(posedge clk) begin
        if (!rst_n || shdn || !in_window) begin
            count_q <= '0;
        end else if (tick && (count_q != CMAX)) begin
            count_q <= count_q + 1'b1;
        end
    end

    // Validated once the full strobe count has been reached.
    assign valid = (count_q == CMAX);

endmodule

// File: rtl/psel_prio_pick.sv
// Module: psel_prio_pick
// Fixed-priority one-hot pick: the lowest set index of req wins.
// Assumes: purely combinational; zero request gives zero grant.
module psel_prio_pick #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);

    // Scan from the highest-priority bit and keep the first request.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/psel_gate_seq.sv
// Module: psel_gate_seq
// Break-before-make gate sequencer. It follows a one-hot target rail. A
// change of target first opens the connected gate, then waits DEAD_CYC
// cycles, then waits for the new rail's reverse flag before closing its gate.
// Assumes: target is one-hot or zero; DEAD_CYC >= 1.
module psel_gate_seq
    import psel_pkg::*;
#(
    parameter int N        = 3,
    parameter int DEAD_CYC = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] target,
    input  logic [N-1:0] rev_ok,
    output logic [N-1:0] gate
);

    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DLAST = DW'(DEAD_CYC - 1);

    seq_state_e    state_q;
    logic [N-1:0]  cur_q;
    logic [DW-1:0] dcnt_q;

    // State, selected rail and dead-time counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_OFF;
            cur_q   <= '0;
            dcnt_q  <= '0;
        end else begin
            case (state_q)
                SQ_OFF: begin
                    if (|target) begin
                        cur_q   <= target;
                        state_q <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (!(|target)) begin
                        cur_q   <= '0;
                        state_q <= SQ_OFF;
                    end else if (target != cur_q) begin
                        cur_q <= target;
                    end else if (|(rev_ok & cur_q)) begin
                        state_q <= SQ_ON;
                    end
                end
                SQ_ON: begin
                    if (target != cur_q) begin
                        dcnt_q  <= '0;
                        state_q <= SQ_DEAD;
                    end
                end
                SQ_DEAD: begin
                    if (dcnt_q == DLAST) begin
                        if (|target) begin
                            cur_q   <= target;
                            state_q <= SQ_WAIT;
                        end else begin
                            cur_q   <= '0;
                            state_q <= SQ_OFF;
                        end
                    end else begin
                        dcnt_q <= dcnt_q + 1'b1;
                    end
                end
                default: state_q <= SQ_OFF;
            endcase
        end
    end

    // Only the connected state drives a gate.
    assign gate = (state_q == SQ_ON) ? cur_q : '0;

endmodule

// File: rtl/psel_ctrl.sv
// Module: psel_ctrl (top)
// Prioritized supply selection controller: per-rail validation timers, a
// fixed-priority pick and a break-before-make gate sequencer.
// Assumes: comparator flags are already synchronous to clk.
module psel_ctrl #(
    parameter int N_RAILS   = 3,
    parameter int VAL_TICKS = 256,
    parameter int DEAD_CYC  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [N_RAILS-1:0] ov,
    input  logic [N_RAILS-1:0] uv,
    input  logic [N_RAILS-1:0] rev_ok,
    input  logic               en,
    input  logic               shdn,
    output logic [N_RAILS-1:0] valid_n,
    output logic [N_RAILS-1:0] gate_on
);

    logic [N_RAILS-1:0] valid;
    logic [N_RAILS-1:0] pick;
    logic [N_RAILS-1:0] target;

    // One validation timer per rail.
    for (genvar g = 0; g < N_RAILS; g++) begin : g_rail
        psel_rail_timer #(.VAL_TICKS(VAL_TICKS)) u_timer (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .ov    (ov[g]),
            .uv    (uv[g]),
            .shdn  (shdn),
            .valid (valid[g])
        );
    end

    psel_prio_pick #(.N(N_RAILS)) u_pick (
        .req   (valid),
        .grant (pick)
    );

    // Enable and shutdown both withdraw the target; only shutdown clears timers.
    assign target = (en && !shdn) ? pick : '0;

    psel_gate_seq #(.N(N_RAILS), .DEAD_CYC(DEAD_CYC)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .target (target),
        .rev_ok (rev_ok),
        .gate   (gate_on)
    );

    // Active-low valid flags.
    assign valid_n = ~valid;

endmodule

// File: rtl/psel_ctrl_chk.sv
// Module: psel_ctrl_chk
// Port-level assertions for psel_ctrl, bound to every instance.
// Assumes: same parameters as the bound instance.
module psel_ctrl_chk #(
    parameter int N_RAILS   = 3,
    parameter int VAL_TICKS = 256,
    parameter int DEAD_CYC  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input logic [N_RAILS-1:0] ov,
    input logic [N_RAILS-1:0] uv,
    input logic [N_RAILS-1:0] rev_ok,
    input logic               en,
    input logic               shdn,
    input logic [N_RAILS-1:0] valid_n,
    input logic [N_RAILS-1:0] gate_on
);

    localparam int OW = $clog2(DEAD_CYC + 2);
    localparam logic [OW-1:0] OMAX = OW'(DEAD_CYC + 1);
    localparam logic [OW-1:0] OMIN = OW'(DEAD_CYC);

    logic [OW-1:0] off_cnt;

    // Cycles with all gates off since the last gate was on (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)          off_cnt <= OMAX;
        else if (|gate_on)   off_cnt <= '0;
        else if (off_cnt != OMAX) off_cnt <= off_cnt + 1'b1;
    end

    p_one_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_on));

    p_no_direct_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_on && |$past(gate_on)) |-> (gate_on == $past(gate_on)));

    p_dead_time_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gate_on) |-> (off_cnt >= OMIN));

    p_en_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_on) |-> $past(en));

    p_shdn_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|gate_on) |-> !$past(shdn));

    for (genvar i = 0; i < N_RAILS; i++) begin : g_chk
        p_valid_needs_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(valid_n[i]) |-> $past(tick));

        p_valid_in_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_n[i] |-> $past(!ov[i] && !uv[i]));

        p_shdn_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !valid_n[i] |-> !$past(shdn));

        p_rev_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_on[i]) |-> $past(rev_ok[i]));

        p_gate_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
            gate_on[i] |-> !$past(valid_n[i]));
    end

endmodule

bind psel_ctrl psel_ctrl_chk #(
    .N_RAILS   (N_RAILS),
    .VAL_TICKS (VAL_TICKS),
    .DEAD_CYC  (DEAD_CYC)
) u_chk (.*);

// File: tb/psel_ctrl_tb.sv
// Directed bench for psel_ctrl: one task per scenario, each self-checking.
module psel_ctrl_tb;

    localparam int N     = 3;
    localparam int VALT  = 8;
    localparam int DEAD  = 4;
    localparam int WDOG  = 20000;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         tick;
    logic [N-1:0] ov, uv, rev_ok;
    logic         en, shdn;
    logic [N-1:0] valid_n, gate_on;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    psel_ctrl #(.N_RAILS(N), .VAL_TICKS(VALT), .DEAD_CYC(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ov(ov), .uv(uv),
        .rev_ok(rev_ok), .en(en), .shdn(shdn),
        .valid_n(valid_n), .gate_on(gate_on)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Reset state: nothing validated, nothing connected.
    task automatic t_reset;
        rst_n = 1'b0; tick = 1'b0; ov = '0; uv = '0; rev_ok = '1;
        en = 1'b1; shdn = 1'b0;
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        chk("R1 reset valid_n", int'(valid_n), 7);
        chk("R6 reset gate_on", int'(gate_on), 0);
    endtask

    // All rails validate together after exactly VALT strobes; rail 0 connects.
    task automatic t_validate;
        ticks(VALT - 1);
        chk("R1 one strobe short", int'(valid_n), 7);
        chk("R9 no gate before valid", int'(gate_on), 0);
        ticks(1);
        chk("R1 validated", int'(valid_n), 0);
        cycles(1);
        chk("R3 rail0 connected", int'(gate_on), 1);
    endtask

    // Rail 0 drops out: dead time, rail 1 takes over; rail 0 must fully revalidate.
    task automatic t_dropout;
        int off;
        off = 0;
        uv[0] = 1'b1;
        cycles(1);
        chk("R2 valid cleared", int'(valid_n[0]), 1);
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (gate_on == 3'b000) off++;
            if (gate_on == 3'b010) break;
        end
        chk("R7 dead gap", off, DEAD + 1);
        chk("R3 rail1 takes over", int'(gate_on), 2);
        ticks(3);
        chk("R2 strobes ignored out of window", int'(valid_n[0]), 1);
        uv[0] = 1'b0;
        ticks(VALT - 1);
        chk("R2 restart from zero", int'(valid_n[0]), 1);
        chk("R3 rail1 still on", int'(gate_on), 2);
        ticks(1);
        chk("R2 revalidated", int'(valid_n[0]), 0);
        cycles(12);
        chk("R3 rail0 preempts", int'(gate_on), 1);
    endtask

    // Enable low opens switches, keeps validation.
    task automatic t_enable;
        en = 1'b0;
        cycles(1);
        chk("R4 gates off", int'(gate_on), 0);
        ticks(3);
        chk("R4 validation kept", int'(valid_n), 0);
        chk("R4 still off", int'(gate_on), 0);
        en = 1'b1;
        cycles(3);
        chk("R4 reconnect", int'(gate_on), 1);
    endtask

    // Reverse flag low holds the selected rail off.
    task automatic t_reverse;
        rev_ok[0] = 1'b0;
        uv[0] = 1'b1;
        cycles(15);
        chk("R3 rail1 on", int'(gate_on), 2);
        uv[0] = 1'b0;
        ticks(VALT);
        cycles(20);
        chk("R8 held off", int'(gate_on), 0);
        rev_ok[0] = 1'b1;
        cycles(1);
        chk("R8 connects after rev", int'(gate_on), 1);
    endtask

    // Shutdown clears everything; full revalidation afterwards.
    task automatic t_shdn;
        shdn = 1'b1;
        cycles(1);
        chk("R5 gates off", int'(gate_on), 0);
        chk("R5 valid cleared", int'(valid_n), 7);
        ticks(2);
        chk("R5 no count in shdn", int'(valid_n), 7);
        shdn = 1'b0;
        ticks(VALT - 1);
        chk("R5 full period needed", int'(valid_n), 7);
        chk("R9 no gate unvalidated", int'(gate_on), 0);
        ticks(1);
        chk("R5 revalidated", int'(valid_n), 0);
        cycles(1);
        chk("R5 reconnect", int'(gate_on), 1);
    endtask

    // Over-limit on rail 2 clears only that rail.
    task automatic t_ov;
        ov[2] = 1'b1;
        cycles(1);
        chk("R2 ov clears rail2", int'(valid_n), 4);
        chk("R3 rail0 unaffected", int'(gate_on), 1);
        ov[2] = 1'b0;
        ticks(VALT);
        chk("R1 rail2 back", int'(valid_n), 0);
    endtask

    initial begin
        t_reset();
        t_validate();
        t_dropout();
        t_enable();
        t_reverse();
        t_shdn();
        t_ov();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule